// File: doc/BRIEF.md
# Segment Selector Translation Unit

This unit turns a logical address into a linear address. A logical address is a 16-bit selector plus a 32-bit offset. A bank of segment registers sits between the two. Each register holds a hidden cached copy of one descriptor's base and limit. Software names a segment register and a selector in a load command. The unit then fetches the 64-bit descriptor from one of two descriptor tables and fills that register's cache.

The selector's table bit picks the table: the global table or the local table. Each table has a base address and a byte limit that come in as inputs. The descriptor is read as two 32-bit words through a simple read port.

Once a register is loaded, translations name only the register and an offset. The unit answers from the cache and never reads the tables. The answer is the base plus the offset, with wrap-around at 2^32. If the offset lies beyond the cached limit, the unit reports a limit fault instead. A flat layout needs no special mode: load every register with a descriptor whose base is zero and whose limit is all ones, and every offset passes through unchanged.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is held and after it is released, ld_busy, ld_done, ld_fault, mem_rd and xl_valid are low. Every segment register then caches base 0 and limit 0.
- R2: A load splits ld_sel as follows: bits 15:3 form the descriptor index and bit 2 selects the table, 0 for global and 1 for local. The first descriptor read goes to the selected table base plus index×8, and the second read goes to that address plus 4.
- R3: The word returned by the first read becomes the segment base. The word returned by the second read becomes the segment's inclusive byte limit.
- R4: If index×8+7 is greater than the selected table's limit, the load issues no read. ld_done and ld_fault are then both high in the cycle after the request, and the target segment register keeps its previous contents.
- R5: A successful load raises ld_done with ld_fault low for exactly one cycle. That cycle is the cycle after the one in which the second read's mem_rvalid was sampled.
- R6: xl_valid is high in the cycle after each xl_req cycle and at no other time. When the offset is within the limit, xl_lin equals the cached base plus xl_off modulo 2^32 and xl_fault is low.
- R7: When xl_off is greater than the cached limit, xl_fault is high and xl_lin is 0.
- R8: Translations never assert mem_rd.
- R9: ld_busy is high from the cycle after an accepted load until the cycle after ld_done. A load request made while ld_busy is high is ignored.
- R10: A segment loaded with base 0 and limit 0xFFFFFFFF maps every offset, including 0xFFFFFFFF, to itself with no fault.
- R11: Once mem_rd is asserted, it stays high with mem_addr stable until a cycle in which mem_rvalid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req | input | 1 | Load command for a segment register |
| ld_seg | input | SEG_W | Segment register to load |
| ld_sel | input | 14 | Selector bits 15:2 (index and table bit) |
| ld_busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | Load finished (one-cycle pulse) |
| ld_fault | output | 1 | Load rejected by the table limit, valid with ld_done |
| gtab_base | input | 32 | Global table base address |
| gtab_limit | input | 16 | Global table byte limit |
| ltab_base | input | 32 | Local table base address |
| ltab_limit | input | 16 | Local table byte limit |
| mem_rd | output | 1 | Read request, held until mem_rvalid |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| xl_req | input | 1 | Translate request |
| xl_seg | input | SEG_W | Segment register to translate through |
| xl_off | input | 32 | Offset |
| xl_valid | output | 1 | Translate result valid |
| xl_lin | output | 32 | Linear address |
| xl_fault | output | 1 | Offset beyond the segment limit |

## Verification
A wrong cached base or limit shows only when a later translation goes through that register. It appears as a wrong xl_lin or a wrong xl_fault one cycle after that request. For this reason every load is followed by translations at the limit, just past it and across the 2^32 wrap. A corrupted fetch state or address shows at once on the read port: the two read addresses are compared, and the ld_done cycle is compared against the cycle of the last returned word. A rejected load that still wrote the cache is exposed by translating through the untouched register immediately afterwards.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEL_HI  = 15;
  localparam int IDX_LO  = 3;
  localparam int TBL_BIT = 2;
  localparam int TLIM_W  = 16;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] limit;
  } seg_cache_t;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_LO,
    FS_HI,
    FS_DONE,
    FS_FLT
  } fetch_st_t;
endpackage

// File: rtl/seg_cache_bank.sv
module seg_cache_bank
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEG_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  seg_cache_t       wr_data,
  input  logic [SEG_W-1:0] rd_seg,
  output seg_cache_t       rd_data
);
  seg_cache_t ent_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_seg == SEG_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= '0;
      else if (ent_en) ent_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SEG; i++)
      if (rd_seg == SEG_W'(i)) rd_data = ent_q[i];
  end
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int AW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_req,
  input  logic [SEG_W-1:0]      ld_seg,
  input  logic [SEL_HI:TBL_BIT] ld_sel,
  input  logic [AW-1:0]         gtab_base,
  input  logic [TLIM_W-1:0]     gtab_limit,
  input  logic [AW-1:0]         ltab_base,
  input  logic [TLIM_W-1:0]     ltab_limit,
  output logic                  mem_rd,
  output logic [AW-1:0]         mem_addr,
  input  logic                  mem_rvalid,
  input  logic [31:0]           mem_rdata,
  output logic                  ld_busy,
  output logic                  ld_done,
  output logic                  ld_fault,
  output logic                  wr_en,
  output logic [SEG_W-1:0]      wr_seg,
  output seg_cache_t            wr_data
);
  localparam int IDX_W = SEL_HI - IDX_LO + 1;

  fetch_st_t          st_q, st_n;
  logic [AW-1:0]      addr_q, addr_n;
  logic [SEG_W-1:0]   seg_q, seg_n;
  logic [31:0]        base_q, base_n;

  logic [IDX_W-1:0]   idx;
  logic [AW-1:0]      tbase;
  logic [TLIM_W-1:0]  tlim;
  logic [TLIM_W-1:0]  last_byte;
  logic               accept;

  assign idx       = ld_sel[SEL_HI:IDX_LO];
  assign tbase     = ld_sel[TBL_BIT] ? ltab_base  : gtab_base;
  assign tlim      = ld_sel[TBL_BIT] ? ltab_limit : gtab_limit;
  assign last_byte = {idx, 3'b111};
  assign accept    = (st_q == FS_IDLE) && ld_req;

  always_comb begin
    st_n    = st_q;
    addr_n  = addr_q;
    seg_n   = seg_q;
    base_n  = base_q;
    wr_en   = 1'b0;
    wr_data = '0;
    unique case (st_q)
      FS_IDLE: if (accept) begin
        seg_n  = ld_seg;
        addr_n = tbase + {{(AW-TLIM_W){1'b0}}, idx, 3'b000};
        st_n   = (last_byte > tlim) ? FS_FLT : FS_LO;
      end
      FS_LO: if (mem_rvalid) begin
        base_n = mem_rdata;
        addr_n = addr_q + AW'(4);
        st_n   = FS_HI;
      end
      FS_HI: if (mem_rvalid) begin
        wr_en   = 1'b1;
        wr_data = '{base: base_q, limit: mem_rdata};
        st_n    = FS_DONE;
      end
      FS_DONE: st_n = FS_IDLE;
      FS_FLT:  st_n = FS_IDLE;
      default: st_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
      seg_q  <= '0;
      base_q <= '0;
    end else begin
      st_q   <= st_n;
      addr_q <= addr_n;
      seg_q  <= seg_n;
      base_q <= base_n;
    end
  end

  assign wr_seg   = seg_q;
  assign mem_rd   = (st_q == FS_LO) || (st_q == FS_HI);
  assign mem_addr = addr_q;
  assign ld_busy  = (st_q != FS_IDLE);
  assign ld_done  = (st_q == FS_DONE) || (st_q == FS_FLT);
  assign ld_fault = (st_q == FS_FLT);
endmodule

// File: rtl/seg_lin_gen.sv
module seg_lin_gen
  import seg_xlate_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xl_req,
  input  logic [AW-1:0] xl_off,
  input  seg_cache_t    ent,
  output logic          xl_valid,
  output logic [AW-1:0] xl_lin,
  output logic          xl_fault
);
  logic          vld_n, flt_n;
  logic [AW-1:0] lin_n;

  always_comb begin
    vld_n = xl_req;
    flt_n = xl_req && (xl_off > ent.limit);
    lin_n = (xl_req && !flt_n) ? (ent.base + xl_off) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_valid <= 1'b0;
      xl_fault <= 1'b0;
      xl_lin   <= '0;
    end else begin
      xl_valid <= vld_n;
      xl_fault <= flt_n;
      xl_lin   <= lin_n;
    end
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEG_W   = $clog2(NUM_SEG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_req,
  input  logic [SEG_W-1:0]      ld_seg,
  input  logic [SEL_HI:TBL_BIT] ld_sel,
  output logic                  ld_busy,
  output logic                  ld_done,
  output logic                  ld_fault,
  input  logic [31:0]           gtab_base,
  input  logic [TLIM_W-1:0]     gtab_limit,
  input  logic [31:0]           ltab_base,
  input  logic [TLIM_W-1:0]     ltab_limit,
  output logic                  mem_rd,
  output logic [31:0]           mem_addr,
  input  logic                  mem_rvalid,
  input  logic [31:0]           mem_rdata,
  input  logic                  xl_req,
  input  logic [SEG_W-1:0]      xl_seg,
  input  logic [31:0]           xl_off,
  output logic                  xl_valid,
  output logic [31:0]           xl_lin,
  output logic                  xl_fault
);
  logic             wr_en;
  logic [SEG_W-1:0] wr_seg;
  seg_cache_t       wr_data;
  seg_cache_t       rd_ent;

  seg_desc_fetch #(.SEG_W(SEG_W), .AW(32)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .ld_req(ld_req), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .gtab_base(gtab_base), .gtab_limit(gtab_limit),
    .ltab_base(ltab_base), .ltab_limit(ltab_limit),
    .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_busy(ld_busy), .ld_done(ld_done), .ld_fault(ld_fault),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_data(wr_data)
  );

  seg_cache_bank #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_data(wr_data),
    .rd_seg(xl_seg), .rd_data(rd_ent)
  );

  seg_lin_gen #(.AW(32)) u_lin (
    .clk(clk), .rst_n(rst_n),
    .xl_req(xl_req), .xl_off(xl_off), .ent(rd_ent),
    .xl_valid(xl_valid), .xl_lin(xl_lin), .xl_fault(xl_fault)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ld_req,
  input logic        ld_busy,
  input logic        ld_done,
  input logic        ld_fault,
  input logic        mem_rd,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        xl_req,
  input logic        xl_valid,
  input logic        xl_fault,
  input logic [31:0] xl_lin
);
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr))); // R11

  AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_done && !ld_fault) |-> ($past(mem_rvalid) && $past(mem_rd))); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> !ld_done); // R5

  AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault |-> (ld_done && $past(ld_req) && !$past(ld_busy) && !$past(mem_rd))); // R4

  AST_XL_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_valid); // R6

  AST_XL_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |-> $past(xl_req)); // R6

  AST_LIMIT_ZERO_LIN: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |-> (xl_valid && xl_lin == 32'h0)); // R7

  AST_BUSY_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> ld_busy); // R9
endmodule

bind seg_xlate_unit seg_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_busy(ld_busy),
  .ld_done(ld_done), .ld_fault(ld_fault), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .xl_req(xl_req),
  .xl_valid(xl_valid), .xl_fault(xl_fault), .xl_lin(xl_lin)
);

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;
  localparam int NSEG = 6;
  localparam int SW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          ld_req = 1'b0;
  logic [SW-1:0] ld_seg = '0;
  logic [15:2]   ld_sel = '0;
  logic          ld_busy, ld_done, ld_fault;
  logic [31:0]   gtab_base = 32'h0000_0040;
  logic [15:0]   gtab_limit = 16'h0017;
  logic [31:0]   ltab_base = 32'h0000_0200;
  logic [15:0]   ltab_limit = 16'h001F;
  logic          mem_rd;
  logic [31:0]   mem_addr;
  logic          mem_rvalid = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          xl_req = 1'b0;
  logic [SW-1:0] xl_seg = '0;
  logic [31:0]   xl_off = '0;
  logic          xl_valid, xl_fault;
  logic [31:0]   xl_lin;

  seg_xlate_unit #(.NUM_SEG(NSEG)) u0 (.*);

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem [256];
  int rd_cnt = 0, wait_cnt = 0, last_rv = 0;
  logic [31:0] rd_log [$];
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0; wait_cnt = 0;
    end else if (mem_rvalid) begin
      mem_rvalid <= 1'b0; wait_cnt = 0;
    end else if (mem_rd) begin
      if (wait_cnt == 2) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[9:2]];
        rd_log.push_back(mem_addr);
        rd_cnt++;
        last_rv = cyc;
      end else wait_cnt++;
    end
  end

  // bench model of the segment caches
  logic [31:0] mb [NSEG];
  logic [31:0] ml [NSEG];

  typedef struct { logic [31:0] lin; logic flt; int c; string tag; } exp_t;
  exp_t sb [$];

  task automatic do_xl(input int seg, input logic [31:0] off, input string tag);
    exp_t e;
    @(negedge clk);
    e.flt = off > ml[seg];
    e.lin = e.flt ? 32'h0 : mb[seg] + off;
    e.c = cyc; e.tag = tag;
    sb.push_back(e);
    xl_req = 1'b1; xl_seg = SW'(seg); xl_off = off;
    @(negedge clk);
    xl_req = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && xl_valid) begin
      if (sb.size() == 0) chk(1'b0, "R6 unexpected xl_valid", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.c + 1, {e.tag, " timing"}, 64'(cyc), 64'(e.c + 1));
        chk(xl_fault == e.flt, {e.tag, " fault"}, 64'(xl_fault), 64'(e.flt));
        chk(xl_lin == e.lin, {e.tag, " lin"}, 64'(xl_lin), 64'(e.lin));
      end
    end
  end

  task automatic do_load(input int seg, input logic [15:0] sel, input bit exp_flt,
                         input logic [31:0] tb_base, input bit poke);
    int n;
    logic [31:0] a0;
    a0 = tb_base + {19'h0, sel[15:3], 3'b000};
    rd_log.delete();
    @(negedge clk);
    ld_req = 1'b1; ld_seg = SW'(seg); ld_sel = sel[15:2];
    @(negedge clk);
    if (poke) begin
      ld_seg = SW'(5); ld_sel = 14'h0002;
      chk(ld_busy == 1'b1, "R9 busy after accept", 64'(ld_busy), 1);
      @(negedge clk);
    end
    ld_req = 1'b0;
    n = 0;
    while (!ld_done && n < 200) begin @(negedge clk); n++; end
    chk(ld_fault == exp_flt, "R4/R5 fault flag", 64'(ld_fault), 64'(exp_flt));
    if (exp_flt) begin
      chk(n == 0, "R4 fault latency", 64'(n), 0);
      chk(rd_log.size() == 0, "R4 no read", 64'(rd_log.size()), 0);
    end else begin
      chk(rd_log.size() == 2, "R2 read count", 64'(rd_log.size()), 2);
      if (rd_log.size() == 2) begin
        chk(rd_log[0] == a0, "R2 first addr", 64'(rd_log[0]), 64'(a0));
        chk(rd_log[1] == a0 + 4, "R2 second addr", 64'(rd_log[1]), 64'(a0 + 4));
        mb[seg] = mem[a0[9:2]];
        ml[seg] = mem[a0[9:2] + 8'd1];
      end
      chk(cyc == last_rv + 1, "R5 done timing", 64'(cyc), 64'(last_rv + 1));
    end
    @(negedge clk);
    chk(!ld_done, "R5 single pulse", 64'(ld_done), 0);
    chk(!ld_busy, "R9 busy clears", 64'(ld_busy), 0);
  endtask

  initial begin
    int rc;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | i;
    mem[18] = 32'h1000_0000; mem[19] = 32'h0000_0FFF;   // global idx1
    mem[20] = 32'h0000_0000; mem[21] = 32'hFFFF_FFFF;   // global idx2 (flat)
    mem[134] = 32'hFFFF_F000; mem[135] = 32'h0000_2000; // local idx3
    for (int i = 0; i < NSEG; i++) begin mb[i] = '0; ml[i] = '0; end

    repeat (3) @(negedge clk);
    chk(!ld_busy && !ld_done && !ld_fault && !mem_rd && !xl_valid, "R1 outputs in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ld_busy && !ld_done && !mem_rd && !xl_valid, "R1 outputs after reset", 0, 0);
    do_xl(0, 32'h0, "R1 seg0 off0");
    do_xl(0, 32'h1, "R1 seg0 off1 faults");

    do_load(1, 16'h0008, 1'b0, gtab_base, 1'b0);          // R2 R3 global
    rc = rd_cnt;
    do_xl(1, 32'h10, "R3 R6 base plus offset");
    do_xl(1, 32'hFFF, "R6 offset at limit");
    do_xl(1, 32'h1000, "R7 offset past limit");
    do_xl(1, 32'hFFFF_FFFF, "R7 large offset");
    repeat (2) @(negedge clk);
    chk(rd_cnt == rc, "R8 no reads on translate", 64'(rd_cnt), 64'(rc));

    do_load(2, 16'h001C, 1'b0, ltab_base, 1'b0);           // R2 local, at table limit
    do_xl(2, 32'h1800, "R6 wraps mod 2^32");
    do_xl(2, 32'h2001, "R7 local limit");

    do_load(3, 16'h0010, 1'b0, gtab_base, 1'b0);
    do_xl(3, 32'hFFFF_FFFF, "R10 flat top");
    do_xl(3, 32'h0, "R10 flat zero");

    do_load(4, 16'h0018, 1'b1, gtab_base, 1'b0);           // R4 beyond global limit
    do_xl(4, 32'h1, "R4 seg4 unchanged");
    do_load(1, 16'h0018, 1'b1, gtab_base, 1'b0);
    do_xl(1, 32'h20, "R4 seg1 unchanged");

    do_load(0, 16'h0010, 1'b0, gtab_base, 1'b1);           // R9 poke to seg5
    do_xl(5, 32'h1, "R9 seg5 untouched");
    do_xl(0, 32'h1234, "R9 seg0 loaded");

    // back-to-back translates
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      e.flt = 1'b0; e.lin = mb[3] + 32'(k * 100); e.c = cyc; e.tag = "R6 back-to-back";
      sb.push_back(e);
      xl_req = 1'b1; xl_seg = 3'd3; xl_off = 32'(k * 100);
      @(negedge clk);
    end
    xl_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R6 all results seen", 64'(sb.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++; fails++;
    $display("FAIL watchdog R6 actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule